// File: doc/BRIEF.md
# Shift/Count Serial Port

This block holds one 4-bit working register. It serves either as a serial shift port or as a down counter, and bit 0 of a 4-bit enable register selects which. In shift mode the register moves one place toward its most significant bit on every instruction-cycle strobe. The serial input enters at bit 0, and the top bit can be presented on the serial data output. In count mode the register loses one on each qualified falling edge of the serial input. A falling edge is qualified only when the low level is held across a minimum number of instruction-cycle strobes, which filters out short glitches. The serial clock output is built from a one-bit clock latch. In shift mode that latch gates the cycle clock, and in count mode it is driven out directly.

A processor core uses the block through two operations. The first is a parallel exchange, which loads the accumulator value into the register and copies the carry bit into the clock latch; the core reads the old register value from `reg_old` at the same edge. The second is a write to the enable register. An exchange always wins over a shift or a decrement in the same clock, and that shift or decrement is discarded.

The input qualifier is a three-state machine. `Q_HIGH` moves to `Q_LOW` when the synchronised input reads low. `Q_LOW` returns to `Q_HIGH` if the input rises before the count completes. `Q_LOW` moves to `Q_DONE` on the strobe that completes the required low width, and it emits a one-clock decrement pulse on that move. `Q_DONE` waits for the input to rise and then returns to `Q_HIGH`. The register logic decodes two modes, `MODE_SHIFT` and `MODE_COUNT`, from enable bit 0.

Top module: `shc_port`

## Requirements
- R1: Reset clears the enable register and the working register to 0 and sets the clock latch to 1. After reset, SO is 0 and SK follows `cyc_clk`, giving one pulse per instruction cycle.
- R2: In shift mode (enable bit 0 = 0), each `cyc_stb` shifts the register left by one place, and the synchronised `si` value enters bit 0.
- R3: In shift mode, SO equals register bit 3 when enable bit 3 is 1, and SO is 0 when enable bit 3 is 0. Shifting continues in both cases.
- R4: In shift mode, SK equals the clock latch ANDed with `cyc_clk`.
- R5: In count mode (enable bit 0 = 1), the register drops by one, wrapping from 0 to 15, once for each falling edge of `si` whose low level lasts for at least MIN_LOW_CYC (default 2) strobes. A low level that spans fewer strobes leaves the register unchanged. Holding `si` low for longer still gives only one decrement.
- R6: In count mode, SO equals enable bit 3 and SK equals the clock latch, whatever the state of `cyc_clk`.
- R7: `reg_old` always presents the register. An `xchg` clock loads `acc_in` into the register and `carry_in` into the clock latch.
- R8: An `xchg` in the same clock as a shift or a decrement takes priority, and that shift or decrement is lost.
- R9: `en_we` loads `en_wdata` into the enable register at the next edge, and the new value selects the mode and output behaviour from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | One-clock pulse at each instruction-cycle boundary |
| cyc_clk | input | 1 | Cycle clock phase used to gate SK in shift mode |
| si | input | 1 | Serial input (asynchronous) |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 4 | Enable register write value |
| xchg | input | 1 | Exchange request |
| acc_in | input | 4 | Accumulator value to load on exchange |
| carry_in | input | 1 | Carry value copied into the clock latch on exchange |
| so | output | 1 | Serial data output |
| sk | output | 1 | Serial clock output |
| reg_old | output | 4 | Current register value, read by the core as the exchange result |

## Verification
A fault in the working register shows up on `reg_old` one clock after the strobe or decrement pulse that caused it. The same fault reaches `so` at once when shift mode has enable bit 3 set. A fault in the clock latch shows up on `sk` during the next high phase of `cyc_clk`, or at once in count mode. A fault in the qualifier is less direct. It can drop a valid edge, accept a short pulse, or decrement more than once, and it only becomes visible as a count that is off by one when the register is next read. The checks therefore read the register after every pulse pattern.

// File: rtl/shc_pkg.sv
package shc_pkg;

    typedef enum logic {
        MODE_SHIFT = 1'b0,
        MODE_COUNT = 1'b1
    } shc_mode_e;

    typedef enum logic [1:0] {
        Q_HIGH = 2'd0,
        Q_LOW  = 2'd1,
        Q_DONE = 2'd2
    } qual_state_e;

    localparam int EN_MODE_BIT = 0;
    localparam int EN_SO_BIT   = 3;

endpackage

// File: rtl/shc_si_qual.sv
module shc_si_qual
    import shc_pkg::*;
#(
    parameter int MIN_LOW_CYC = 2,
    parameter int SYNC_DEPTH  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_stb,
    input  logic si,
    output logic si_s,
    output logic dec_pulse
);

    localparam int CW = $clog2(MIN_LOW_CYC + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(MIN_LOW_CYC - 1);

    logic [SYNC_DEPTH-1:0] sync_q;
    qual_state_e           st_q;
    logic [CW-1:0]         lowcnt_q;
    logic                  qualify;

    // input synchroniser, idle level high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_DEPTH-2:0], si};
        end
    end

    assign si_s = sync_q[SYNC_DEPTH-1];

    assign qualify = (st_q == Q_LOW) && !si_s && cyc_stb && (lowcnt_q == LAST_CNT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= Q_HIGH;
            lowcnt_q <= '0;
        end else begin
            unique case (st_q)
                Q_HIGH: begin
                    if (!si_s) begin
                        st_q     <= Q_LOW;
                        lowcnt_q <= '0;
                    end
                end
                Q_LOW: begin
                    if (si_s) begin
                        st_q <= Q_HIGH;
                    end else if (cyc_stb) begin
                        if (lowcnt_q == LAST_CNT) begin
                            st_q <= Q_DONE;
                        end else begin
                            lowcnt_q <= lowcnt_q + 1'b1;
                        end
                    end
                end
                Q_DONE: begin
                    if (si_s) begin
                        st_q <= Q_HIGH;
                    end
                end
                default: st_q <= Q_HIGH;
            endcase
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_pulse <= 1'b0;
        end else begin
            dec_pulse <= qualify;
        end
    end

endmodule

// File: rtl/shc_core.sv
module shc_core
    import shc_pkg::*;
#(
    parameter int W    = 4,
    parameter int EN_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_stb,
    input  logic            si_s,
    input  logic            dec_pulse,
    input  logic            en_we,
    input  logic [EN_W-1:0] en_wdata,
    input  logic            xchg,
    input  logic [W-1:0]    acc_in,
    input  logic            carry_in,
    output logic [W-1:0]    reg_q,
    output logic [EN_W-1:0] en_q,
    output logic            sk_lat,
    output shc_mode_e       mode
);

    logic [W-1:0] reg_nxt;

    assign mode = shc_mode_e'(en_q[EN_MODE_BIT]);

    always_comb begin
        reg_nxt = reg_q;
        if (xchg) begin
            reg_nxt = acc_in;
        end else begin
            unique case (mode)
                MODE_SHIFT: if (cyc_stb)   reg_nxt = {reg_q[W-2:0], si_s};
                MODE_COUNT: if (dec_pulse) reg_nxt = reg_q - 1'b1;
                default:    reg_nxt = reg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q  <= '0;
            en_q   <= '0;
            sk_lat <= 1'b1;
        end else begin
            reg_q <= reg_nxt;
            if (en_we) begin
                en_q <= en_wdata;
            end
            if (xchg) begin
                sk_lat <= carry_in;
            end
        end
    end

endmodule

// File: rtl/shc_outmux.sv
module shc_outmux
    import shc_pkg::*;
#(
    parameter int W    = 4,
    parameter int EN_W = 4
) (
    input  shc_mode_e       mode,
    input  logic [EN_W-1:0] en_q,
    input  logic [W-1:0]    reg_q,
    input  logic            sk_lat,
    input  logic            cyc_clk,
    output logic            so,
    output logic            sk
);

    always_comb begin
        unique case (mode)
            MODE_SHIFT: begin
                so = en_q[EN_SO_BIT] & reg_q[W-1];
                sk = sk_lat & cyc_clk;
            end
            MODE_COUNT: begin
                so = en_q[EN_SO_BIT];
                sk = sk_lat;
            end
            default: begin
                so = 1'b0;
                sk = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/shc_port.sv
module shc_port
    import shc_pkg::*;
#(
    parameter int W           = 4,
    parameter int EN_W        = 4,
    parameter int MIN_LOW_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_stb,
    input  logic            cyc_clk,
    input  logic            si,
    input  logic            en_we,
    input  logic [EN_W-1:0] en_wdata,
    input  logic            xchg,
    input  logic [W-1:0]    acc_in,
    input  logic            carry_in,
    output logic            so,
    output logic            sk,
    output logic [W-1:0]    reg_old
);

    logic            si_s;
    logic            dec_pulse;
    logic [W-1:0]    reg_q;
    logic [EN_W-1:0] en_q;
    logic            sk_lat;
    shc_mode_e       mode;

    shc_si_qual #(
        .MIN_LOW_CYC (MIN_LOW_CYC),
        .SYNC_DEPTH  (2)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_stb   (cyc_stb),
        .si        (si),
        .si_s      (si_s),
        .dec_pulse (dec_pulse)
    );

    shc_core #(
        .W    (W),
        .EN_W (EN_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_stb   (cyc_stb),
        .si_s      (si_s),
        .dec_pulse (dec_pulse),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .xchg      (xchg),
        .acc_in    (acc_in),
        .carry_in  (carry_in),
        .reg_q     (reg_q),
        .en_q      (en_q),
        .sk_lat    (sk_lat),
        .mode      (mode)
    );

    shc_outmux #(
        .W    (W),
        .EN_W (EN_W)
    ) u_out (
        .mode    (mode),
        .en_q    (en_q),
        .reg_q   (reg_q),
        .sk_lat  (sk_lat),
        .cyc_clk (cyc_clk),
        .so      (so),
        .sk      (sk)
    );

    assign reg_old = reg_q;

endmodule

// File: rtl/shc_port_chk.sv
module shc_port_chk #(
    parameter int W    = 4,
    parameter int EN_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cyc_stb,
    input logic            cyc_clk,
    input logic            en_we,
    input logic [EN_W-1:0] en_wdata,
    input logic            xchg,
    input logic [W-1:0]    acc_in,
    input logic            carry_in,
    input logic            so,
    input logic            sk,
    input logic [W-1:0]    reg_q,
    input logic [EN_W-1:0] en_q,
    input logic            sk_lat,
    input logic            dec_pulse
);

    AST_RESET_STATE: assert property (@(posedge clk) $rose(rst_n) |-> (en_q == '0) && (reg_q == '0) && sk_lat); // R1

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && !xchg && !en_q[0]) |=> (reg_q[W-1:1] == $past(reg_q[W-2:0]))); // R2

    AST_SO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[0] && !en_q[EN_W-1]) |-> !so); // R3

    AST_SK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[0] && !cyc_clk) |-> !sk); // R4

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[0] && !xchg && !dec_pulse) |=> (reg_q == $past(reg_q))); // R5

    AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[0] && !xchg && dec_pulse) |=> (reg_q == $past(reg_q) - 1'b1)); // R5

    AST_DEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_pulse |=> !dec_pulse); // R5

    AST_COUNT_SK: assert property (@(posedge clk) disable iff (!rst_n)
        en_q[0] |-> (sk == sk_lat)); // R6

    AST_XCHG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        xchg |=> ((reg_q == $past(acc_in)) && (sk_lat == $past(carry_in)))); // R8

    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> (en_q == $past(en_wdata))); // R9

endmodule

bind shc_port shc_port_chk #(
    .W    (W),
    .EN_W (EN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_stb   (cyc_stb),
    .cyc_clk   (cyc_clk),
    .en_we     (en_we),
    .en_wdata  (en_wdata),
    .xchg      (xchg),
    .acc_in    (acc_in),
    .carry_in  (carry_in),
    .so        (so),
    .sk        (sk),
    .reg_q     (reg_q),
    .en_q      (en_q),
    .sk_lat    (sk_lat),
    .dec_pulse (dec_pulse)
);

// File: tb/test_shc_port.sv
module test_shc_port;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // fields: [8] enable bit 3, [7:4] shifted pattern, [3:0] exchange value
    localparam logic [8:0] VEC [NVEC] = '{
        9'b1_1011_0101,
        9'b0_1101_1010,
        9'b1_0110_1111,
        9'b1_1001_0000,
        9'b0_1111_0011,
        9'b1_0000_1100
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_stb = 1'b0;
    logic       cyc_clk = 1'b0;
    logic       si = 1'b1;
    logic       en_we = 1'b0;
    logic [3:0] en_wdata = '0;
    logic       xchg = 1'b0;
    logic [3:0] acc_in = '0;
    logic       carry_in = 1'b0;
    logic       so;
    logic       sk;
    logic [3:0] reg_old;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shc_port i_shc_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_stb  (cyc_stb),
        .cyc_clk  (cyc_clk),
        .si       (si),
        .en_we    (en_we),
        .en_wdata (en_wdata),
        .xchg     (xchg),
        .acc_in   (acc_in),
        .carry_in (carry_in),
        .so       (so),
        .sk       (sk),
        .reg_old  (reg_old)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one instruction cycle: clock high for two clocks, strobe in the fourth
    task automatic cyc(input bit with_xchg = 1'b0);
        for (int p = 0; p < 5; p++) begin
            @(negedge clk);
            cyc_clk = (p < 2);
            cyc_stb = (p == 3);
            if (with_xchg) xchg = (p == 3);
        end
        xchg = 1'b0;
        #1;
    endtask

    task automatic set_en(input logic [3:0] v);
        @(negedge clk);
        en_we = 1'b1;
        en_wdata = v;
        @(negedge clk);
        en_we = 1'b0;
        #1;
    endtask

    task automatic xch(input logic [3:0] a, input logic c);
        @(negedge clk);
        xchg = 1'b1;
        acc_in = a;
        carry_in = c;
        @(negedge clk);
        xchg = 1'b0;
        #1;
    endtask

    task automatic sk_probe(input string req, input logic exp_hi, input logic exp_lo);
        @(negedge clk);
        cyc_clk = 1'b1;
        #1 chk(req, {3'b0, sk}, {3'b0, exp_hi});
        @(negedge clk);
        cyc_clk = 1'b0;
        #1 chk(req, {3'b0, sk}, {3'b0, exp_lo});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 reg", reg_old, 4'h0);
        chk("R1 so", {3'b0, so}, 4'h0);
        sk_probe("R1 sk sync", 1'b1, 1'b0);

        // table of shift-mode patterns
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0] pat;
            logic [3:0] acc;
            logic       e3;
            e3  = VEC[v][8];
            pat = VEC[v][7:4];
            acc = VEC[v][3:0];
            set_en({e3, 3'b000});
            for (int b = 3; b >= 0; b--) begin
                si = pat[b];
                cyc();
            end
            chk("R2 shift", reg_old, pat);
            chk("R3 so", {3'b0, so}, {3'b0, e3 & pat[3]});
            xch(acc, pat[0]);
            chk("R7 exchange", reg_old, acc);
            sk_probe("R4 sk gate", pat[0], 1'b0);
        end

        // R8 exchange beats a shift in the same clock
        set_en(4'b0000);
        si = 1'b1;
        acc_in = 4'h5;
        carry_in = 1'b0;
        cyc(1'b1);
        chk("R8 priority", reg_old, 4'h5);
        cyc();
        chk("R2 after xchg", reg_old, 4'hB);
        sk_probe("R4 latch low", 1'b0, 1'b0);

        // count mode
        si = 1'b1;
        cyc();
        cyc();
        set_en(4'b0001);
        xch(4'h0, 1'b1);
        chk("R6 so", {3'b0, so}, 4'h0);
        sk_probe("R6 sk", 1'b1, 1'b1);
        set_en(4'b1001);
        chk("R9 so follows en3", {3'b0, so}, 4'h1);
        si = 1'b0;
        repeat (3) cyc();
        si = 1'b1;
        cyc();
        chk("R5 wrap", reg_old, 4'hF);
        si = 1'b0;
        cyc();
        si = 1'b1;
        cyc();
        cyc();
        chk("R5 short pulse", reg_old, 4'hF);
        si = 1'b0;
        repeat (6) cyc();
        chk("R5 single dec", reg_old, 4'hE);
        si = 1'b1;
        cyc();
        cyc();
        chk("R5 held", reg_old, 4'hE);
        set_en(4'b0001);
        chk("R6 so en3 clear", {3'b0, so}, 4'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule